// File: doc/BRIEF.md
# Memory-Mapped Hardware Lock Cache

This block keeps one bit of lock state per lock variable in dedicated flops beside a shared multiprocessor bus, away from main memory, so that spinning on a lock never turns into memory traffic. Up to four bus masters reach the locks with plain loads and stores. Any address whose upper bits match a fixed tag is decoded into the lock space. A load works as an atomic test-and-set: it returns 1 and claims the lock if the lock was free, and it returns 0 if the lock was taken. A store of 0 hands the lock back. Only the master that holds the lock may release it. A store of 0 from anyone else is dropped and raises a sticky error flag.

The 128 locks are split into two banks of 64. The short bank serves brief critical sections. The long bank serves long ones, and every release in the long bank sends a one-cycle pulse that carries the lock index, so that an interrupt controller can wake the tasks waiting on that lock. The master ID is the port position (0 to 3). Each lock is a small state machine with the states LK_FREE and LK_HELD. Its transitions are TAKE (LK_FREE to LK_HELD, which records the owner) and DROP (LK_HELD to LK_FREE, which clears the owner). Both states hold in place when neither transition fires.

Top module: `lc_lock_cache`

## Requirements
- R1: A request hits the lock space only when address bits [15:7] equal the tag 9'h0A5. Bit 6 selects the bank (0 = short, 1 = long) and bits [5:0] select the lock in that bank. A request that misses gets no response and changes no lock.
- R2: A read hit on a free lock sets rsp_valid and rsp_grant for that master in the next cycle, and the lock becomes held by that master.
- R3: A read hit on a held lock sets rsp_valid with rsp_grant = 0 in the next cycle and leaves the lock and its owner unchanged.
- R4: A write of 0 by the owner of a held lock releases the lock. The write gets rsp_valid with rsp_grant = 0 in the next cycle.
- R5: A write of 0 by a master that is not the owner, or a write of 0 to a free lock, has no effect on the lock and sets err_flag in the next cycle. err_flag then stays set until reset.
- R6: A write of 1 to a lock address changes no lock and does not set err_flag. It still gets rsp_valid in the next cycle.
- R7: When several masters hit the same lock in one cycle, only the lowest master ID is served. Every other master gets rsp_valid with rsp_grant = 0, and its access has no effect and raises no error.
- R8: A release in the long bank raises rel_valid[m] of the releasing master for exactly one cycle, the cycle after the write, with rel_index[m] holding the lock number (address bits [5:0]). A release in the short bank raises no pulse.
- R9: Synchronous reset frees every lock, clears every owner, and clears err_flag, rsp_valid, rsp_grant and rel_valid.
- R10: Masters that hit different locks in the same cycle are all served in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 4 | Request strobe, one bit per master |
| req_write | input | 4 | 1 = store, 0 = load, per master |
| req_wdata | input | 4 | Store data bit per master (0 releases the lock) |
| req_addr | input | 64 | Word address per master, 16 bits each, master m at [16m+15:16m] |
| rsp_valid | output | 4 | Lock-space access completed, one cycle after the request |
| rsp_grant | output | 4 | Load result: 1 = lock acquired |
| rel_valid | output | 4 | One-cycle long-bank release pulse per master |
| rel_index | output | 24 | Released lock number per master, 6 bits each |
| err_flag | output | 1 | Sticky illegal-release flag |

## Verification
The checker assumes that each master drives at most one request per cycle, that every request and its address are stable across the clock edge, and that no request is driven while reset is asserted. It also assumes that a master never relies on a response before the cycle after its request. The bench drives all inputs on the falling edge and holds the strobes low during reset. Its random addresses are drawn from a small pool of short-bank and long-bank locks, plus tag-mismatched addresses, so that same-lock collisions, wrong-owner releases and out-of-range accesses all occur often while every request stays well formed.

// File: rtl/lc_pkg.sv
package lc_pkg;
    typedef enum logic [0:0] {
        LK_FREE = 1'b0,
        LK_HELD = 1'b1
    } lock_state_e;
endpackage

// File: rtl/lc_decode.sv
module lc_decode #(
    parameter int ADDR_W = 16,
    parameter int LOCK_W = 7,
    parameter int TAG_W  = ADDR_W - LOCK_W,
    parameter logic [TAG_W-1:0] BASE_TAG = '0
) (
    input  logic              valid,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [LOCK_W-1:0] idx
);
    assign hit = valid && (addr[ADDR_W-1:LOCK_W] == BASE_TAG);
    assign idx = addr[LOCK_W-1:0];
endmodule

// File: rtl/lc_arbiter.sv
module lc_arbiter #(
    parameter int NUM_MASTERS = 4,
    parameter int LOCK_W      = 7
) (
    input  logic [NUM_MASTERS-1:0]        hit,
    input  logic [NUM_MASTERS*LOCK_W-1:0] idx_flat,
    output logic [NUM_MASTERS-1:0]        win
);
    for (genvar m = 0; m < NUM_MASTERS; m++) begin : g_master
        logic won;
        always_comb begin
            won = hit[m];
            for (int n = 0; n < m; n++) begin
                if (hit[n] && (idx_flat[n*LOCK_W +: LOCK_W] == idx_flat[m*LOCK_W +: LOCK_W]))
                    won = 1'b0;
            end
        end
        assign win[m] = won;
    end
endmodule

// File: rtl/lc_lock_slot.sv
module lc_lock_slot
    import lc_pkg::*;
#(
    parameter int MID_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             take,
    input  logic             drop,
    input  logic [MID_W-1:0] take_id,
    output logic             held,
    output logic [MID_W-1:0] owner
);
    lock_state_e      state_q, state_d;
    logic [MID_W-1:0] owner_q, owner_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= LK_FREE;
            owner_q <= '0;
        end else begin
            state_q <= state_d;
            owner_q <= owner_d;
        end
    end

    always_comb begin
        state_d = state_q;
        owner_d = owner_q;
        unique case (state_q)
            LK_FREE: if (take) begin
                state_d = LK_HELD;
                owner_d = take_id;
            end
            LK_HELD: if (drop) begin
                state_d = LK_FREE;
                owner_d = '0;
            end
        endcase
    end

    assign held  = (state_q == LK_HELD);
    assign owner = owner_q;
endmodule

// File: rtl/lc_lock_cache.sv
module lc_lock_cache #(
    parameter int          NUM_MASTERS = 4,
    parameter int          ADDR_W      = 16,
    parameter int          BANK_LOCKS  = 64,
    parameter int unsigned LOCK_BASE   = 32'h0A5
) (
    input  logic                                    clk,
    input  logic                                    rst,
    input  logic [NUM_MASTERS-1:0]                  req_valid,
    input  logic [NUM_MASTERS-1:0]                  req_write,
    input  logic [NUM_MASTERS-1:0]                  req_wdata,
    input  logic [NUM_MASTERS*ADDR_W-1:0]           req_addr,
    output logic [NUM_MASTERS-1:0]                  rsp_valid,
    output logic [NUM_MASTERS-1:0]                  rsp_grant,
    output logic [NUM_MASTERS-1:0]                  rel_valid,
    output logic [NUM_MASTERS*$clog2(BANK_LOCKS)-1:0] rel_index,
    output logic                                    err_flag
);
    localparam int MID_W     = $clog2(NUM_MASTERS);
    localparam int IDX_W     = $clog2(BANK_LOCKS);
    localparam int LOCK_W    = IDX_W + 1;
    localparam int NUM_LOCKS = 2 * BANK_LOCKS;
    localparam int TAG_W     = ADDR_W - LOCK_W;
    localparam logic [TAG_W-1:0] BASE_TAG = TAG_W'(LOCK_BASE);

    logic [NUM_MASTERS-1:0]        hit, win;
    logic [NUM_MASTERS*LOCK_W-1:0] idx_flat;
    logic [NUM_MASTERS-1:0]        do_take, do_drop, do_bad;
    logic [NUM_LOCKS-1:0]          held_vec;
    logic [MID_W-1:0]              owner_all [NUM_LOCKS];

    // Address decode, one per master
    for (genvar m = 0; m < NUM_MASTERS; m++) begin : g_dec
        lc_decode #(
            .ADDR_W  (ADDR_W),
            .LOCK_W  (LOCK_W),
            .TAG_W   (TAG_W),
            .BASE_TAG(BASE_TAG)
        ) u_dec (
            .valid(req_valid[m]),
            .addr (req_addr[m*ADDR_W +: ADDR_W]),
            .hit  (hit[m]),
            .idx  (idx_flat[m*LOCK_W +: LOCK_W])
        );
    end

    // Same-lock conflicts: lowest master ID wins
    lc_arbiter #(
        .NUM_MASTERS(NUM_MASTERS),
        .LOCK_W     (LOCK_W)
    ) u_arb (
        .hit     (hit),
        .idx_flat(idx_flat),
        .win     (win)
    );

    // Per-master decision against the addressed lock
    for (genvar m = 0; m < NUM_MASTERS; m++) begin : g_op
        logic [LOCK_W-1:0] li;
        logic              cur_held;
        logic              is_owner;
        logic              rel_req;
        assign li       = idx_flat[m*LOCK_W +: LOCK_W];
        assign cur_held = held_vec[li];
        assign is_owner = cur_held && (owner_all[li] == MID_W'(m));
        assign rel_req  = hit[m] && win[m] && req_write[m] && !req_wdata[m];
        assign do_take[m] = hit[m] && win[m] && !req_write[m] && !cur_held;
        assign do_drop[m] = rel_req && is_owner;
        assign do_bad[m]  = rel_req && !is_owner;
    end

    // Lock slots
    for (genvar k = 0; k < NUM_LOCKS; k++) begin : g_slot
        logic             take_k, drop_k;
        logic [MID_W-1:0] tid_k;
        always_comb begin
            take_k = 1'b0;
            drop_k = 1'b0;
            tid_k  = '0;
            for (int m = 0; m < NUM_MASTERS; m++) begin
                if (idx_flat[m*LOCK_W +: LOCK_W] == LOCK_W'(k)) begin
                    if (do_take[m]) begin
                        take_k = 1'b1;
                        tid_k  = MID_W'(m);
                    end
                    if (do_drop[m]) drop_k = 1'b1;
                end
            end
        end
        lc_lock_slot #(.MID_W(MID_W)) u_slot (
            .clk    (clk),
            .rst    (rst),
            .take   (take_k),
            .drop   (drop_k),
            .take_id(tid_k),
            .held   (held_vec[k]),
            .owner  (owner_all[k])
        );
    end

    // Registered outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= '0;
            rsp_grant <= '0;
            rel_valid <= '0;
            rel_index <= '0;
            err_flag  <= 1'b0;
        end else begin
            rsp_valid <= hit;
            rsp_grant <= do_take;
            err_flag  <= err_flag | (|do_bad);
            for (int m = 0; m < NUM_MASTERS; m++) begin
                rel_valid[m] <= do_drop[m] && idx_flat[m*LOCK_W + IDX_W];
                rel_index[m*IDX_W +: IDX_W] <= idx_flat[m*LOCK_W +: IDX_W];
            end
        end
    end
endmodule

// File: rtl/lc_lock_cache_chk.sv
module lc_lock_cache_chk #(
    parameter int          NUM_MASTERS = 4,
    parameter int          ADDR_W      = 16,
    parameter int          BANK_LOCKS  = 64,
    parameter int unsigned LOCK_BASE   = 32'h0A5
) (
    input logic                                      clk,
    input logic                                      rst,
    input logic [NUM_MASTERS-1:0]                    req_valid,
    input logic [NUM_MASTERS-1:0]                    req_write,
    input logic [NUM_MASTERS-1:0]                    req_wdata,
    input logic [NUM_MASTERS*ADDR_W-1:0]             req_addr,
    input logic [NUM_MASTERS-1:0]                    rsp_valid,
    input logic [NUM_MASTERS-1:0]                    rsp_grant,
    input logic [NUM_MASTERS-1:0]                    rel_valid,
    input logic [NUM_MASTERS*$clog2(BANK_LOCKS)-1:0] rel_index,
    input logic                                      err_flag
);
    localparam int IDX_W  = $clog2(BANK_LOCKS);
    localparam int LOCK_W = IDX_W + 1;
    localparam int TAG_W  = ADDR_W - LOCK_W;
    localparam logic [TAG_W-1:0] BASE_TAG = TAG_W'(LOCK_BASE);

    logic [NUM_MASTERS-1:0] in_space;
    for (genvar m = 0; m < NUM_MASTERS; m++) begin : g_sp
        assign in_space[m] = req_valid[m] &&
            (req_addr[m*ADDR_W+LOCK_W +: TAG_W] == BASE_TAG);
    end

    for (genvar m = 0; m < NUM_MASTERS; m++) begin : g_m
        // R1: a response follows exactly the lock-space hits
        p_rsp_hit_r1: assert property (@(posedge clk) disable iff (rst)
            !$past(rst) |-> (rsp_valid[m] == $past(in_space[m])));

        // R2: a grant only answers a load that hit the lock space
        p_grant_load_r2: assert property (@(posedge clk) disable iff (rst)
            rsp_grant[m] |-> $past(in_space[m] && !req_write[m]));

        // R8: a release pulse only follows a store of 0 to the long bank, with its index
        p_rel_long_r8: assert property (@(posedge clk) disable iff (rst)
            rel_valid[m] |-> ($past(in_space[m] && req_write[m] && !req_wdata[m] &&
                                    req_addr[m*ADDR_W + IDX_W]) &&
                              (rel_index[m*IDX_W +: IDX_W] ==
                               $past(req_addr[m*ADDR_W +: IDX_W]))));

        for (genvar n = m + 1; n < NUM_MASTERS; n++) begin : g_n
            // R7: two loads of one lock in a cycle never both win
            p_single_winner_r7: assert property (@(posedge clk) disable iff (rst)
                (!$past(rst) && $past(in_space[m] && in_space[n] &&
                    !req_write[m] && !req_write[n] &&
                    (req_addr[m*ADDR_W +: LOCK_W] == req_addr[n*ADDR_W +: LOCK_W])))
                |-> !(rsp_grant[m] && rsp_grant[n]));
        end
    end

    // R5: the error flag stays set until reset
    p_err_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(err_flag)) |-> err_flag);

    // R9: outputs are quiet in the first cycle after reset
    p_reset_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (rsp_valid == '0 && rsp_grant == '0 && rel_valid == '0 && !err_flag));
endmodule

bind lc_lock_cache lc_lock_cache_chk #(
    .NUM_MASTERS(NUM_MASTERS),
    .ADDR_W     (ADDR_W),
    .BANK_LOCKS (BANK_LOCKS),
    .LOCK_BASE  (LOCK_BASE)
) u_chk (.*);

// File: tb/tb_lc_lock_cache.sv
module tb_lc_lock_cache;
    localparam logic [8:0] TAG = 9'h0A5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  req_valid = '0, req_write = '0, req_wdata = '0;
    logic [63:0] req_addr = '0;
    logic [3:0]  rsp_valid, rsp_grant, rel_valid;
    logic [23:0] rel_index;
    logic        err_flag;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Reference state
    bit       m_held [128];
    bit [1:0] m_own  [128];
    bit       m_err;

    // Stimulus for the next step
    bit [3:0]  sv, sw, sd;
    bit [15:0] sa [4];

    always #4 clk = ~clk;

    lc_lock_cache dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_write(req_write), .req_wdata(req_wdata),
        .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_grant(rsp_grant),
        .rel_valid(rel_valid), .rel_index(rel_index), .err_flag(err_flag)
    );

    function automatic bit [15:0] mk(bit bank, int idx);
        return {TAG, bank, idx[5:0]};
    endfunction

    task automatic chk(string tg, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tg, what, act, exp);
        end
    endtask

    task automatic clr();
        sv = '0; sw = '0; sd = '0;
        for (int m = 0; m < 4; m++) sa[m] = '0;
    endtask

    task automatic put(int m, bit wr, bit dat, bit [15:0] ad);
        sv[m] = 1'b1; sw[m] = wr; sd[m] = dat; sa[m] = ad;
    endtask

    task automatic model_clear();
        for (int k = 0; k < 128; k++) begin
            m_held[k] = 1'b0;
            m_own[k]  = '0;
        end
        m_err = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        req_valid = '0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        model_clear();
    endtask

    // One request cycle: compute expectations, drive, then compare after the edge
    task automatic step();
        bit       hit [4];
        bit [6:0] li [4];
        bit       win [4];
        bit       eg [4], erel [4], tk [4], dr [4];
        string    tg [4];
        for (int m = 0; m < 4; m++) begin
            hit[m] = sv[m] && (sa[m][15:7] == TAG);
            li[m]  = sa[m][6:0];
        end
        for (int m = 0; m < 4; m++) begin
            win[m] = hit[m];
            for (int n = 0; n < m; n++)
                if (hit[n] && li[n] == li[m]) win[m] = 1'b0;
            eg[m] = 0; erel[m] = 0; tk[m] = 0; dr[m] = 0;
            if (!hit[m])                tg[m] = "R1";
            else if (!win[m])           tg[m] = "R7";
            else if (!sw[m]) begin
                if (m_held[li[m]])      tg[m] = "R3";
                else begin              tg[m] = "R2"; eg[m] = 1; tk[m] = 1; end
            end else if (sd[m])         tg[m] = "R6";
            else if (m_held[li[m]] && m_own[li[m]] == 2'(m)) begin
                dr[m] = 1; erel[m] = li[m][6];
                tg[m] = li[m][6] ? "R8" : "R4";
            end else                    tg[m] = "R5";
        end
        for (int m = 0; m < 4; m++) begin
            if (tk[m]) begin m_held[li[m]] = 1; m_own[li[m]] = 2'(m); end
            if (dr[m]) begin m_held[li[m]] = 0; m_own[li[m]] = '0; end
            if (tg[m] == "R5") m_err = 1;
        end
        req_valid = sv; req_write = sw; req_wdata = sd;
        for (int m = 0; m < 4; m++) req_addr[m*16 +: 16] = sa[m];
        @(posedge clk);
        #2;
        for (int m = 0; m < 4; m++) begin
            chk(tg[m], $sformatf("rsp_valid[%0d]", m), int'(rsp_valid[m]), int'(hit[m]));
            chk(tg[m], $sformatf("rsp_grant[%0d]", m), int'(rsp_grant[m]), int'(eg[m]));
            chk(erel[m] ? "R8" : tg[m], $sformatf("rel_valid[%0d]", m),
                int'(rel_valid[m]), int'(erel[m]));
            if (erel[m])
                chk("R8", $sformatf("rel_index[%0d]", m),
                    int'(rel_index[m*6 +: 6]), int'(li[m][5:0]));
        end
        chk("R5", "err_flag", int'(err_flag), int'(m_err));
        req_valid = '0;
        @(negedge clk);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240));
        model_clear();
        clr();
        @(negedge clk);
        do_reset();

        // R9: idle after reset
        clr(); step();
        chk("R9", "err after reset", int'(err_flag), 0);
        chk("R9", "rsp_valid after reset", int'(rsp_valid), 0);

        // R2 then R3
        clr(); put(0, 0, 0, mk(0, 5)); step();
        clr(); put(1, 0, 0, mk(0, 5)); step();
        // R6: owner writes 1, lock stays held, no error
        clr(); put(0, 1, 1, mk(0, 5)); step();
        clr(); put(2, 0, 0, mk(0, 5)); step();
        chk("R6", "no error after write of 1", int'(err_flag), 0);
        // R4: owner releases a short lock, no pulse; then another master takes it
        clr(); put(0, 1, 0, mk(0, 5)); step();
        clr(); put(1, 0, 0, mk(0, 5)); step();
        // R8: long-bank take and release
        clr(); put(2, 0, 0, mk(1, 9)); step();
        clr(); put(2, 1, 0, mk(1, 9)); step();
        // R7: two loads of one lock, lower ID wins
        clr(); put(3, 0, 0, mk(1, 20)); put(1, 0, 0, mk(1, 20)); step();
        // R7: owner release against a load in the same cycle
        clr(); put(1, 1, 0, mk(1, 20)); put(2, 0, 0, mk(1, 20)); step();
        clr(); put(2, 0, 0, mk(1, 20)); step();
        // R10: four different locks in one cycle
        clr();
        put(0, 0, 0, mk(0, 40)); put(1, 0, 0, mk(1, 41));
        put(2, 0, 0, mk(0, 42)); put(3, 0, 0, mk(1, 43));
        step();
        chk("R10", "all four granted", int'(rsp_grant), 15);
        // R1: tag miss leaves the lock alone
        clr(); put(0, 0, 0, {TAG ^ 9'h001, 1'b0, 6'd50}); step();
        clr(); put(3, 0, 0, mk(0, 50)); step();
        // R5: wrong owner release, then release of a free lock
        clr(); put(0, 1, 0, mk(0, 50)); step();
        clr(); put(1, 0, 0, mk(0, 50)); step();
        clr(); put(2, 1, 0, mk(1, 60)); step();
        // R9: reset clears error and held locks
        do_reset();
        clr(); put(1, 0, 0, mk(0, 50)); step();
        chk("R9", "err cleared by reset", int'(err_flag), 0);

        // Constrained random phase
        for (int i = 0; i < 4000; i++) begin
            if ($urandom % 600 == 0) begin
                do_reset();
            end else begin
                clr();
                for (int m = 0; m < 4; m++) begin
                    if ($urandom % 10 < 7) begin
                        bit [15:0] ad;
                        int pick = $urandom % 4;
                        int idx  = (pick == 3) ? 63 : pick;
                        ad = mk(1'($urandom), idx);
                        if ($urandom % 10 == 0) ad[15:7] = TAG ^ 9'h100;
                        put(m, ($urandom % 10) < 4, ($urandom % 5) == 0, ad);
                    end
                end
            end
            step();
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule